// File: doc/BRIEF.md
# Digital Loss-of-Signal Ones-Density Detector

This block watches a retimed single-rail receive bit stream, taking one bit on each cycle where the bit-valid strobe is high. It raises a digital loss-of-signal alarm once a long unbroken run of zeros arrives. It lowers the alarm only after the stream shows adequate ones density again, judged over fixed blocks of received bits.

Setting and clearing follow separate rules. The alarm sets on a consecutive-zero count. It clears through a windowed density test that starts with the first bit after the alarm is declared. A strict mode, chosen by an input, also requires every clearing window to be free of long zero runs.

The block drives two outputs. One is a live condition output that follows the alarm. The other is a latched status bit that records each declaration until a status read strobe clears it.

Top module: `dlos_monitor`

## Requirements
- R1: When the 100th consecutive valid zero is presented, `los_live` and `los_stat` are both high in the next cycle.
- R2: A run of 99 valid zeros followed by a valid one leaves `los_live` low.
- R3: While the alarm is active, valid bits are grouped into non-overlapping 100-bit windows. The first window begins with the first valid bit after the declaring cycle. If a window holds 13 or more ones and strict mode is off, `los_live` is low in the cycle after the window's last bit.
- R4: A window with 12 or fewer ones keeps the alarm. The next window is judged on its own bits only.
- R5: If `strict_en` is high in the cycle of a window's last bit, that window also fails when it contains a run of 15 or more zeros. A longest run of 14 does not make it fail. Runs are counted inside the window only.
- R6: `los_stat` stays high after a declaration until a read, even after `los_live` has returned low.
- R7: When `stat_rd` is high, `los_stat` is low in the next cycle. If a declaration falls in the same cycle as the read, the declaration wins and `los_stat` stays high.
- R8: The consecutive-zero count keeps running through the alarm and across its clearing. Trailing zeros of a passing window therefore count toward the next declaration. The count saturates and never wraps during arbitrarily long zero runs.
- R9: Cycles with `bit_vld` low change no counter, whatever the value of `bit_in`.
- R10: During and right after reset, `los_live` and `los_stat` are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | High when `bit_in` carries a received bit |
| bit_in | input | 1 | Received data bit, 1 = mark |
| strict_en | input | 1 | Strict clearing mode: rejects windows containing a long zero run |
| stat_rd | input | 1 | Status read strobe, clears the latched status |
| los_live | output | 1 | Live alarm condition |
| los_stat | output | 1 | Latched alarm status, cleared on read |

## Verification
Directed patterns probe both edges of every threshold:
- A 99-zero run and a 100-zero run separate the declaring count.
- Windows with 12 and 13 evenly spread ones bracket the density threshold.
- Strict windows whose longest zero run is 14 or 15 bracket the run limit.

Further patterns cover the remaining rules:
- Invalid cycles mixed with zeros and ones inside a run show that only valid bits count.
- A passing window ending in 15 zeros, followed by 85 zeros, shows the zero count carrying across the clear.
- A 400-zero run tests saturation.

Random segments then alternate long zero bursts with bursts at several ones densities, along with random strobe gaps, mode changes and reads. This exercises windows that land near each threshold.

// File: rtl/dlos_pkg.sv
package dlos_pkg;

  typedef enum logic {
    ST_CLEAR = 1'b0,
    ST_LOST  = 1'b1
  } los_state_e;

  // saturating increment: never exceeds cap
  function automatic int unsigned sat_inc(int unsigned v, int unsigned cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

  // density test: enough marks in the window
  function automatic logic density_met(int unsigned ones, int unsigned min_ones);
    return ones >= min_ones;
  endfunction

  // run length reaching a limit
  function automatic logic run_reached(int unsigned run, int unsigned lim);
    return run >= lim;
  endfunction

endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run
  import dlos_pkg::*;
#(
  parameter int unsigned SET_RUN = 100,
  localparam int unsigned CW = $clog2(SET_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic [CW-1:0] zrun_cnt,
  output logic          run_hit
);

  logic [CW-1:0] zrun_q;
  logic [CW-1:0] zrun_inc;

  always_comb begin
    zrun_inc = CW'(sat_inc(32'(zrun_q), SET_RUN));
    run_hit  = bit_vld && !bit_in && run_reached(32'(zrun_inc), SET_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun_q <= '0;
    end else if (bit_vld) begin
      zrun_q <= bit_in ? '0 : zrun_inc;
    end
  end

  assign zrun_cnt = zrun_q;

endmodule

// File: rtl/dlos_clear_window.sv
module dlos_clear_window
  import dlos_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 100,
  parameter int unsigned MIN_ONES    = 13,
  parameter int unsigned STRICT_RUN  = 15,
  parameter bit          HAS_STRICT  = 1'b1,
  localparam int unsigned PW = $clog2(WIN_LEN),
  localparam int unsigned OW = $clog2(WIN_LEN + 1),
  localparam int unsigned RW = $clog2(STRICT_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic strict_en,
  output logic win_end,
  output logic win_pass
);

  logic [PW-1:0] pos_q;
  logic [OW-1:0] ones_q, ones_nxt;
  logic          take, last;
  logic          strict_fail;

  assign take     = armed && bit_vld;
  assign last     = take && (pos_q == PW'(WIN_LEN - 1));
  assign ones_nxt = ones_q + OW'(bit_in);

  generate
    if (HAS_STRICT) begin : g_strict
      logic [RW-1:0] run_q, run_nxt;
      logic          bad_q, bad_nxt;

      always_comb begin
        run_nxt = bit_in ? '0 : RW'(sat_inc(32'(run_q), STRICT_RUN));
        bad_nxt = bad_q || run_reached(32'(run_nxt), STRICT_RUN);
      end

      always_ff @(posedge clk) begin
        if (!rst_n || !armed || last) begin
          run_q <= '0;
          bad_q <= 1'b0;
        end else if (take) begin
          run_q <= run_nxt;
          bad_q <= bad_nxt;
        end
      end

      assign strict_fail = strict_en && bad_nxt;
    end else begin : g_plain
      assign strict_fail = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || last) begin
      pos_q  <= '0;
      ones_q <= '0;
    end else if (take) begin
      pos_q  <= pos_q + 1'b1;
      ones_q <= ones_nxt;
    end
  end

  assign win_end  = last;
  assign win_pass = last && density_met(32'(ones_nxt), MIN_ONES) && !strict_fail;

endmodule

// File: rtl/dlos_stat_latch.sv
module dlos_stat_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_evt,
  output logic stat
);

  always_ff @(posedge clk) begin
    if (!rst_n)       stat <= 1'b0;
    else if (set_evt) stat <= 1'b1;
    else if (rd_evt)  stat <= 1'b0;
  end

endmodule

// File: rtl/dlos_monitor.sv
module dlos_monitor
  import dlos_pkg::*;
#(
  parameter int unsigned SET_RUN    = 100,
  parameter int unsigned WIN_LEN    = 100,
  parameter int unsigned MIN_ONES   = 13,
  parameter int unsigned STRICT_RUN = 15,
  parameter bit          HAS_STRICT = 1'b1,
  localparam int unsigned CW = $clog2(SET_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic strict_en,
  input  logic stat_rd,
  output logic los_live,
  output logic los_stat
);

  los_state_e    state_q;
  logic [CW-1:0] zrun_cnt;
  logic          run_hit;
  logic          declare_evt;
  logic          win_end_evt;
  logic          win_pass_evt;

  dlos_zero_run #(.SET_RUN(SET_RUN)) zrun_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .zrun_cnt (zrun_cnt),
    .run_hit  (run_hit)
  );

  assign declare_evt = run_hit && (state_q == ST_CLEAR);

  dlos_clear_window #(
    .WIN_LEN    (WIN_LEN),
    .MIN_ONES   (MIN_ONES),
    .STRICT_RUN (STRICT_RUN),
    .HAS_STRICT (HAS_STRICT)
  ) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (state_q == ST_LOST),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .strict_en (strict_en),
    .win_end   (win_end_evt),
    .win_pass  (win_pass_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            state_q <= ST_CLEAR;
    else if (declare_evt)  state_q <= ST_LOST;
    else if (win_pass_evt) state_q <= ST_CLEAR;
  end

  dlos_stat_latch stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (declare_evt),
    .rd_evt  (stat_rd),
    .stat    (los_stat)
  );

  assign los_live = (state_q == ST_LOST);

endmodule

// File: rtl/dlos_monitor_chk.sv
module dlos_monitor_chk #(
  parameter int unsigned SET_RUN = 100,
  parameter int unsigned CW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_vld,
  input logic          bit_in,
  input logic          stat_rd,
  input logic          los_live,
  input logic          los_stat,
  input logic          declare_evt,
  input logic          win_end_evt,
  input logic          win_pass_evt,
  input logic [CW-1:0] zrun_cnt
);

  p_declare_r1: assert property (@(posedge clk) disable iff (!rst_n)
    declare_evt |=> (los_live && los_stat));

  p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_live) |-> $past(bit_vld && !bit_in));

  p_clear_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_live) |-> $past(win_end_evt && win_pass_evt));

  p_pass_only_when_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_evt |-> los_live);

  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (los_stat && !stat_rd) |=> los_stat);

  p_stat_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !declare_evt) |=> !los_stat);

  p_zrun_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(zrun_cnt) <= SET_RUN);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(los_live) && $stable(zrun_cnt)));

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!los_live && !los_stat && zrun_cnt == '0));

endmodule

bind dlos_monitor dlos_monitor_chk #(.SET_RUN(SET_RUN), .CW(CW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_vld      (bit_vld),
  .bit_in       (bit_in),
  .stat_rd      (stat_rd),
  .los_live     (los_live),
  .los_stat     (los_stat),
  .declare_evt  (declare_evt),
  .win_end_evt  (win_end_evt),
  .win_pass_evt (win_pass_evt),
  .zrun_cnt     (zrun_cnt)
);

// File: tb/dlos_monitor_tb_top.sv
module dlos_monitor_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic strict_en = 1'b0;
  logic stat_rd = 1'b0;
  logic los_live, los_stat;

  int total = 0;
  int bad = 0;

  // reference state
  bit m_live = 1'b0;
  bit m_stat = 1'b0;
  int m_zrun = 0;
  int m_wpos = 0;
  bit m_win[100];

  always #10 clk = ~clk;

  dlos_monitor dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .strict_en (strict_en),
    .stat_rd   (stat_rd),
    .los_live  (los_live),
    .los_stat  (los_stat)
  );

  // judge a stored window: marks and longest zero stretch
  function automatic bit window_ok(bit strict);
    int marks = 0;
    int cur = 0;
    int longest = 0;
    for (int i = 0; i < 100; i++) begin
      if (m_win[i]) begin
        marks++;
        cur = 0;
      end else begin
        cur++;
        if (cur > longest) longest = cur;
      end
    end
    return (marks * 8 >= 100) && !(strict && longest >= 15);
  endfunction

  task automatic check(string tag);
    total++;
    if (los_live !== m_live || los_stat !== m_stat) begin
      bad++;
      $display("FAIL %s: live=%b exp=%b stat=%b exp=%b", tag, los_live, m_live, los_stat, m_stat);
    end
  endtask

  task automatic step(bit v, bit b, bit rd, string tag);
    bit decl;
    bit pass;
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    stat_rd = rd;
    decl = !m_live && v && !b && (m_zrun + 1 >= 100);
    pass = 1'b0;
    if (m_live && v) begin
      m_win[m_wpos] = b;
      m_wpos++;
      if (m_wpos == 100) begin
        pass = window_ok(strict_en);
        m_wpos = 0;
      end
    end
    if (v) m_zrun = b ? 0 : ((m_zrun < 1000) ? m_zrun + 1 : m_zrun);
    if (decl) m_stat = 1'b1;
    else if (rd) m_stat = 1'b0;
    if (decl) m_live = 1'b1;
    else if (pass) m_live = 1'b0;
    @(posedge clk);
    #5;
    check(tag);
  endtask

  task automatic zeros(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, tag);
  endtask

  // leading zero run, then evenly spaced marks
  task automatic send_window(int ones_n, int run_len, string tag);
    int g = (100 - run_len) / ones_n;
    for (int p = 0; p < 100; p++) begin
      bit b = (p >= run_len) && ((p - run_len) % g == 0) && ((p - run_len) / g < ones_n);
      step(1'b1, b, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #5;
    check("R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R10 after reset");

    // R2: one short of the limit
    zeros(99, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");

    // R9: invalid cycles inside a run change nothing
    zeros(60, "R9");
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b0, 1'b0, "R9");
      step(1'b0, 1'b1, 1'b0, "R9");
    end
    zeros(39, "R9");
    zeros(1, "R1 declare");

    // R3: 13 marks clears; window ends in 15 zeros
    send_window(13, 0, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, "R7 read");
    step(1'b0, 1'b0, 1'b0, "R7");

    // R8: trailing zeros carry over to the next declaration
    zeros(84, "R8");
    zeros(1, "R8 redeclare");

    // R4: 12 marks fails, then a fresh window of 13 passes
    send_window(12, 0, "R4");
    send_window(13, 0, "R4");
    zeros(84, "R8");
    step(1'b1, 1'b0, 1'b1, "R7 read with declare");
    step(1'b0, 1'b0, 1'b1, "R7");

    // R5: strict mode, run of 15 fails, 14 passes
    strict_en = 1'b1;
    send_window(13, 15, "R5");
    send_window(13, 14, "R5");
    strict_en = 1'b0;
    zeros(100, "R1");

    // R8: very long run while lost, then clear
    zeros(400, "R8");
    send_window(13, 0, "R8");

    // constrained random segments
    for (int s = 0; s < 250; s++) begin
      int len;
      int dens;
      if ($urandom_range(1, 0) == 0) begin
        len = $urandom_range(160, 50);
        for (int i = 0; i < len; i++)
          step($urandom_range(9, 0) != 0, 1'b0, $urandom_range(19, 0) == 0, "R1 random");
      end else begin
        len = $urandom_range(300, 50);
        dens = ($urandom_range(2, 0) == 0) ? 20 : (($urandom_range(1, 0) == 0) ? 8 : 5);
        strict_en = $urandom_range(1, 0);
        for (int i = 0; i < len; i++)
          step($urandom_range(9, 0) != 0, $urandom_range(dens - 1, 0) == 0,
               $urandom_range(19, 0) == 0, "R3/R5 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule